// File: doc/BRIEF.md
# Per-Connection Cell List Builder

This block takes one cell descriptor per cell cycle: a connection number and a cell buffer address. Each field has its own parity bit, and the pair has a null marker. Each accepted buffer address is appended to a singly linked list kept for its connection. Three on-chip tables hold those lists. A head table, indexed by connection, holds the first buffer and an ownership flag. A tail table, indexed by connection, holds the last buffer. A link table, indexed by buffer, holds the next buffer of each list. The all-ones address is the end-of-list marker and is never linked.

The connection stream and the address stream each enter a small input queue. The queues advance in step, so a pair stays together. A pair is dropped if it is a null, if either field fails its parity check, if its connection is not owned, or if its address is the end-of-list marker. Each parity failure is counted per field, and a push into a full queue is counted as an overflow. All three counters saturate and clear when software reads them. The block works only while its control register holds the active pattern. Software reaches the control register, the counters and all three tables through a simple register port. For every pair it processes, the block reports the connection number it looked up, together with a copy of that report delayed by exactly two clock cycles.

Top module: `cell_list_enq`

## Requirements
- R1: Pairs leave the input queues only while the control register equals `ACTIVE_PAT` (default 8'h4E). A write with bit 0 clear stores the value with bit 0 forced to 0. A write with bit 0 set clears the register, so it then reads 0.
- R2: After reset, the control register and all counters read 0, both queues are empty and not full, tail and link entries hold the all-ones end marker, and head entries hold ownership 0 with an all-ones pointer.
- R3: Each queue holds `FIFO_DEPTH` entries and raises its full flag when it holds that many and its empty flag when it holds none. A push while either queue is full is discarded and adds one to the overflow counter.
- R4: A pair with the null marker set is never linked, and its parity is not counted.
- R5: Parity is even: the XOR of a field and its parity bit must be 0. A failing connection field adds one to the ID error counter, and a failing address field adds one to the address error counter. A pair with both failures adds to both counters. A failing pair is not linked.
- R6: A clean pair whose connection has ownership bit 0 changes no table entry.
- R7: If the connection's head pointer is the end marker, the new address is written to both its head pointer and its tail, and the ownership bit is kept.
- R8: Otherwise the new address is written to the link entry of the current tail, the tail becomes the new address, and the head is unchanged.
- R9: A clean pair whose address equals the end marker is discarded without counting.
- R10: Counters saturate at 2^CNT_W-1 and clear on a software read. A read in the same cycle as an increment returns the old value and leaves the counter at 1.
- R11: Register map. reg_space 0 is control, with offsets 0 = control, 1 = ID errors, 2 = address errors, 3 = overflow. reg_space 1 is head (ownership at bit ADDR_W, pointer below it), 2 is tail and 3 is link, each indexed by reg_addr. Read data is valid the cycle after the access. Writes to counter offsets are ignored.
- R12: In any cycle with reg_en high, no pair leaves the queues. Processing resumes afterwards.
- R13: look_vld/look_id mark each processed pair and its connection. look_vld_d2/look_id_d2 repeat them exactly two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Push a pair this cycle |
| in_id | input | ID_W | Connection number |
| in_id_par | input | 1 | Parity bit of in_id |
| in_addr | input | ADDR_W | Cell buffer address |
| in_addr_par | input | 1 | Parity bit of in_addr |
| in_null | input | 1 | Pair is a null |
| id_fifo_empty | output | 1 | Connection queue empty |
| id_fifo_full | output | 1 | Connection queue full |
| addr_fifo_empty | output | 1 | Address queue empty |
| addr_fifo_full | output | 1 | Address queue full |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | Access is a write |
| reg_space | input | 2 | Register space select |
| reg_addr | input | RA_W | Offset or table index |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, one cycle after access |
| look_vld | output | 1 | A pair is processed this cycle |
| look_id | output | ID_W | Connection looked up |
| look_vld_d2 | output | 1 | look_vld two cycles later |
| look_id_d2 | output | ID_W | look_id two cycles later |

## Verification
The overflow counter can increment in the same cycle that software reads it, because pushes are accepted at the queue boundary regardless of register traffic. The bench fills the idle queues and then pushes once more while issuing a read of the overflow counter at the same clock edge. The read must return the count from before that push, and a second read must return exactly 1, so the coinciding event is neither lost nor counted twice. The bench also holds a register access while a pair waits in the queue, and requires the empty flag to stay low until the access ends.

// File: rtl/llq_pkg.sv
package llq_pkg;

  typedef enum logic [1:0] {
    SP_CTRL = 2'd0,
    SP_HEAD = 2'd1,
    SP_TAIL = 2'd2,
    SP_LINK = 2'd3
  } space_e;

  localparam int CR_CFG   = 0;
  localparam int CR_IDERR = 1;
  localparam int CR_ADERR = 2;
  localparam int CR_OVF   = 3;
  localparam int NUM_CNT  = 3;

  // even parity: field bits plus parity bit XOR to zero
  function automatic logic par_ok(input logic [31:0] field, input logic pbit);
    return (^field) == pbit;
  endfunction

  // saturating counter step with read-clear; an increment in the clear cycle survives
  function automatic logic [31:0] sat_next(input logic [31:0] cur, input logic inc,
                                           input logic clr, input logic [31:0] maxv);
    logic [31:0] base;
    base = clr ? 32'd0 : cur;
    if (inc && base != maxv) base = base + 32'd1;
    return base;
  endfunction

  // control register update: bit 0 set wipes the register
  function automatic logic [7:0] cfg_next(input logic [7:0] wdata);
    return wdata[0] ? 8'h00 : {wdata[7:1], 1'b0};
  endfunction

endpackage

// File: rtl/llq_fifo.sv
module llq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp      <= ptr_inc(wp);
      end
      if (do_pop) rp <= ptr_inc(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));  // R3
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R3

endmodule

// File: rtl/llq_errcnt.sv
module llq_errcnt import llq_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(sat_next(32'(cnt), inc, clr, 32'(MAXV)));
  end

  AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> (cnt == MAXV));  // R10
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt == '0));  // R10

endmodule

// File: rtl/llq_lists.sv
module llq_lists import llq_pkg::*; #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 5,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_req,
  input  logic [ID_W-1:0]   enq_id,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic              sw_we,
  input  space_e            sw_space,
  input  logic [RA_W-1:0]   sw_idx,
  input  logic [ADDR_W:0]   sw_wdata,
  output logic [ADDR_W:0]   head_rd,
  output logic [ADDR_W-1:0] tail_rd,
  output logic [ADDR_W-1:0] link_rd,
  output logic              ev_first,
  output logic              ev_append,
  output logic              ev_unowned
);
  localparam int NCONN = 1 << ID_W;
  localparam int NBUF  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] NULLP = '1;

  logic              head_own [NCONN];
  logic [ADDR_W-1:0] head_ptr [NCONN];
  logic [ADDR_W-1:0] tail_v   [NCONN];
  logic [ADDR_W-1:0] link_v   [NBUF];

  logic              cur_own;
  logic [ADDR_W-1:0] cur_head, cur_tail;
  logic [ID_W-1:0]   sw_cidx;
  logic [ADDR_W-1:0] sw_bidx;

  assign cur_own  = head_own[enq_id];
  assign cur_head = head_ptr[enq_id];
  assign cur_tail = tail_v[enq_id];
  assign sw_cidx  = sw_idx[ID_W-1:0];
  assign sw_bidx  = sw_idx[ADDR_W-1:0];

  assign ev_first   = enq_req && cur_own && (cur_head == NULLP);
  assign ev_append  = enq_req && cur_own && (cur_head != NULLP);
  assign ev_unowned = enq_req && !cur_own;

  for (genvar c = 0; c < NCONN; c++) begin : g_conn
    logic              r_own;
    logic [ADDR_W-1:0] r_head, r_tail;
    logic              hit;
    assign hit = (enq_id == ID_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_own  <= 1'b0;
        r_head <= NULLP;
      end else if (sw_we && sw_space == SP_HEAD && sw_cidx == ID_W'(c)) begin
        r_own  <= sw_wdata[ADDR_W];
        r_head <= sw_wdata[ADDR_W-1:0];
      end else if (ev_first && hit) begin
        r_head <= enq_addr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_tail <= NULLP;
      else if (sw_we && sw_space == SP_TAIL && sw_cidx == ID_W'(c))
        r_tail <= sw_wdata[ADDR_W-1:0];
      else if ((ev_first || ev_append) && hit)
        r_tail <= enq_addr;
    end

    assign head_own[c] = r_own;
    assign head_ptr[c] = r_head;
    assign tail_v[c]   = r_tail;
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [ADDR_W-1:0] r_link;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_link <= NULLP;
      else if (sw_we && sw_space == SP_LINK && sw_bidx == ADDR_W'(b))
        r_link <= sw_wdata[ADDR_W-1:0];
      else if (ev_append && cur_tail == ADDR_W'(b))
        r_link <= enq_addr;
    end
    assign link_v[b] = r_link;
  end

  assign head_rd = {head_own[sw_cidx], head_ptr[sw_cidx]};
  assign tail_rd = tail_v[sw_cidx];
  assign link_rd = link_v[sw_bidx];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    enq_req |-> ($countones({ev_first, ev_append, ev_unowned}) == 1));  // R6
  AST_FIRST_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> (head_ptr[$past(enq_id)] == $past(enq_addr)) &&
                 (tail_v[$past(enq_id)] == $past(enq_addr)));  // R7
  AST_APPEND_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_append |=> (link_v[$past(cur_tail)] == $past(enq_addr)) &&
                  (head_ptr[$past(enq_id)] == $past(cur_head)));  // R8
  AST_UNOWNED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_unowned && !sw_we) |=> (tail_v[$past(enq_id)] == $past(cur_tail)));  // R6

endmodule

// File: rtl/cell_list_enq.sv
module cell_list_enq import llq_pkg::*; #(
  parameter int         ID_W       = 4,
  parameter int         ADDR_W     = 5,
  parameter int         FIFO_DEPTH = 4,
  parameter int         CNT_W      = 8,
  parameter int         REG_W      = 8,
  parameter logic [7:0] ACTIVE_PAT = 8'h4E,
  parameter int         RA_W       = (ID_W > ADDR_W) ? ID_W : ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic              in_id_par,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_addr_par,
  input  logic              in_null,
  output logic              id_fifo_empty,
  output logic              id_fifo_full,
  output logic              addr_fifo_empty,
  output logic              addr_fifo_full,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_space,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              look_vld,
  output logic [ID_W-1:0]   look_id,
  output logic              look_vld_d2,
  output logic [ID_W-1:0]   look_id_d2
);
  localparam int IDQ_W   = ID_W + 2;
  localparam int ADQ_W   = ADDR_W + 1;
  localparam int LOOK_DLY = 2;
  localparam logic [ADDR_W-1:0] NULLP = '1;

  space_e            space;
  logic [7:0]        cfg_q;
  logic              active, accept, ovf_ev, pop;
  logic [IDQ_W-1:0]  idq_out;
  logic [ADQ_W-1:0]  adq_out;
  logic              q_null, q_idp, q_adp, id_ok, addr_ok;
  logic [ID_W-1:0]   q_id;
  logic [ADDR_W-1:0] q_addr;
  logic              id_err_ev, addr_err_ev, enq_req;
  logic              ev_first, ev_append, ev_unowned;
  logic [ADDR_W:0]   head_rd;
  logic [ADDR_W-1:0] tail_rd, link_rd;
  logic [NUM_CNT-1:0] cnt_inc, cnt_clr;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic              ctrl_wr_cfg;

  assign space  = space_e'(reg_space);
  assign active = (cfg_q == ACTIVE_PAT);
  assign accept = in_valid && !id_fifo_full && !addr_fifo_full;
  assign ovf_ev = in_valid && (id_fifo_full || addr_fifo_full);
  assign pop    = active && !id_fifo_empty && !addr_fifo_empty && !reg_en;

  llq_fifo #(.W(IDQ_W), .DEPTH(FIFO_DEPTH)) u_idq (
    .clk(clk), .rst_n(rst_n), .push(accept),
    .din({in_null, in_id_par, in_id}), .pop(pop), .dout(idq_out),
    .empty(id_fifo_empty), .full(id_fifo_full));

  llq_fifo #(.W(ADQ_W), .DEPTH(FIFO_DEPTH)) u_adq (
    .clk(clk), .rst_n(rst_n), .push(accept),
    .din({in_addr_par, in_addr}), .pop(pop), .dout(adq_out),
    .empty(addr_fifo_empty), .full(addr_fifo_full));

  assign {q_null, q_idp, q_id} = idq_out;
  assign {q_adp, q_addr}       = adq_out;
  assign id_ok   = par_ok(32'(q_id), q_idp);
  assign addr_ok = par_ok(32'(q_addr), q_adp);

  assign id_err_ev   = pop && !q_null && !id_ok;
  assign addr_err_ev = pop && !q_null && !addr_ok;
  assign enq_req     = pop && !q_null && id_ok && addr_ok && (q_addr != NULLP);

  llq_lists #(.ID_W(ID_W), .ADDR_W(ADDR_W), .RA_W(RA_W)) u_lists (
    .clk(clk), .rst_n(rst_n),
    .enq_req(enq_req), .enq_id(q_id), .enq_addr(q_addr),
    .sw_we(reg_en && reg_we), .sw_space(space), .sw_idx(reg_addr),
    .sw_wdata(reg_wdata[ADDR_W:0]),
    .head_rd(head_rd), .tail_rd(tail_rd), .link_rd(link_rd),
    .ev_first(ev_first), .ev_append(ev_append), .ev_unowned(ev_unowned));

  // counters: index 0 ID errors, 1 address errors, 2 overflow
  assign cnt_inc = {ovf_ev, addr_err_ev, id_err_ev};
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign cnt_clr[k] = reg_en && !reg_we && space == SP_CTRL &&
                        reg_addr == RA_W'(CR_IDERR + k);
    llq_errcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[k]), .clr(cnt_clr[k]),
      .cnt(cnt_val[k]));
  end

  assign ctrl_wr_cfg = reg_en && reg_we && space == SP_CTRL &&
                       reg_addr == RA_W'(CR_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg_q <= 8'h00;
    else if (ctrl_wr_cfg) cfg_q <= cfg_next(reg_wdata[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_en && !reg_we) begin
      case (space)
        SP_CTRL: begin
          if (reg_addr == RA_W'(CR_CFG))        reg_rdata <= REG_W'(cfg_q);
          else if (reg_addr == RA_W'(CR_IDERR)) reg_rdata <= REG_W'(cnt_val[0]);
          else if (reg_addr == RA_W'(CR_ADERR)) reg_rdata <= REG_W'(cnt_val[1]);
          else if (reg_addr == RA_W'(CR_OVF))   reg_rdata <= REG_W'(cnt_val[2]);
          else                                  reg_rdata <= '0;
        end
        SP_HEAD: reg_rdata <= REG_W'(head_rd);
        SP_TAIL: reg_rdata <= REG_W'(tail_rd);
        default: reg_rdata <= REG_W'(link_rd);
      endcase
    end
  end

  // lookup report and its two-cycle delayed copy
  assign look_vld = pop;
  assign look_id  = q_id;

  logic            dly_vld [LOOK_DLY+1];
  logic [ID_W-1:0] dly_id  [LOOK_DLY+1];
  assign dly_vld[0] = look_vld;
  assign dly_id[0]  = look_id;
  for (genvar s = 1; s <= LOOK_DLY; s++) begin : g_dly
    logic            r_vld;
    logic [ID_W-1:0] r_id;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_vld <= 1'b0;
        r_id  <= '0;
      end else begin
        r_vld <= dly_vld[s-1];
        r_id  <= dly_id[s-1];
      end
    end
    assign dly_vld[s] = r_vld;
    assign dly_id[s]  = r_id;
  end
  assign look_vld_d2 = dly_vld[LOOK_DLY];
  assign look_id_d2  = dly_id[LOOK_DLY];

  AST_CFG_RESET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_cfg && reg_wdata[0]) |=> (cfg_q == 8'h00));  // R1
  AST_NO_POP_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> !look_vld);  // R12
  AST_LOOK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    look_vld_d2 |-> (look_id_d2 == $past(look_id, 2)));  // R13
  AST_NULL_NOT_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
    (look_vld && q_null) |-> !(ev_first || ev_append));  // R4
  AST_IDLE_NO_LOOK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !look_vld);  // R1

endmodule

// File: tb/test_cell_list_enq.sv
`timescale 1ns/1ps
module test_cell_list_enq;
  localparam int ID_W = 4, ADDR_W = 5, FIFO_DEPTH = 4, CNT_W = 3, REG_W = 8, RA_W = 5;
  localparam int NCONN = 16, NBUF = 32, CMAX = 7;
  localparam logic [4:0] NP  = 5'h1f;
  localparam logic [7:0] ACT = 8'h4E;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_id_par, in_addr_par, in_null;
  logic [ID_W-1:0] in_id;
  logic [ADDR_W-1:0] in_addr;
  logic id_fifo_empty, id_fifo_full, addr_fifo_empty, addr_fifo_full;
  logic reg_en, reg_we;
  logic [1:0] reg_space;
  logic [RA_W-1:0] reg_addr;
  logic [REG_W-1:0] reg_wdata, reg_rdata;
  logic look_vld, look_vld_d2;
  logic [ID_W-1:0] look_id, look_id_d2;

  cell_list_enq #(.ID_W(ID_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W),
                  .REG_W(REG_W), .ACTIVE_PAT(ACT)) i_cell_list_enq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_id_par(in_id_par),
    .in_addr(in_addr), .in_addr_par(in_addr_par), .in_null(in_null),
    .id_fifo_empty(id_fifo_empty), .id_fifo_full(id_fifo_full),
    .addr_fifo_empty(addr_fifo_empty), .addr_fifo_full(addr_fifo_full),
    .reg_en(reg_en), .reg_we(reg_we), .reg_space(reg_space), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .look_vld(look_vld), .look_id(look_id), .look_vld_d2(look_vld_d2), .look_id_d2(look_id_d2));

  int checks = 0, errors = 0;
  bit done = 0;

  logic       m_own  [NCONN];
  logic [4:0] m_head [NCONN];
  logic [4:0] m_tail [NCONN];
  logic [4:0] m_link [NBUF];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int sp, input int a, input int d);
    reg_en = 1; reg_we = 1; reg_space = 2'(sp); reg_addr = RA_W'(a); reg_wdata = REG_W'(d);
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input int sp, input int a, output int d);
    reg_en = 1; reg_we = 0; reg_space = 2'(sp); reg_addr = RA_W'(a);
    @(negedge clk);
    d = int'(reg_rdata);
    reg_en = 0;
  endtask

  task automatic set_pair(input int id, input int ad, input bit nul, input bit idbad, input bit adbad);
    in_valid = 1; in_id = ID_W'(id); in_addr = ADDR_W'(ad); in_null = nul;
    in_id_par   = (^in_id) ^ idbad;
    in_addr_par = (^in_addr) ^ adbad;
  endtask

  task automatic push(input int id, input int ad, input bit nul, input bit idbad, input bit adbad);
    set_pair(id, ad, nul, idbad, adbad);
    @(negedge clk);
    in_valid = 0;
  endtask

  // reference list update, applied in push order
  task automatic model_enq(input int id, input int ad);
    if (m_own[id] && ad != int'(NP)) begin
      if (m_head[id] == NP) begin
        m_head[id] = 5'(ad);
      end else begin
        m_link[m_tail[id]] = 5'(ad);
      end
      m_tail[id] = 5'(ad);
    end
  endtask

  // two-cycle delay monitor (R13)
  logic       h1_v = 0, h2_v = 0;
  logic [3:0] h1_i = 0, h2_i = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (h2_v != look_vld_d2 || (h2_v && h2_i != look_id_d2))
        check(0, "R13", {look_vld_d2, look_id_d2}, {h2_v, h2_i});
      else if (h2_v)
        check(1, "R13", 0, 0);
      h2_v = h1_v; h2_i = h1_i;
      h1_v = look_vld; h1_i = look_id;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, ide, ade, nga, kind;
    rst_n = 0; in_valid = 0; in_id = 0; in_addr = 0; in_id_par = 0; in_addr_par = 0; in_null = 0;
    reg_en = 0; reg_we = 0; reg_space = 0; reg_addr = 0; reg_wdata = 0;
    for (int c = 0; c < NCONN; c++) begin
      m_own[c] = (c % 8 != 1); m_head[c] = NP; m_tail[c] = NP;
    end
    for (int b = 0; b < NBUF; b++) m_link[b] = NP;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    reg_rd(0, 0, d); check(d == 0, "R2 cfg", d, 0);
    for (int k = 1; k <= 3; k++) begin
      reg_rd(0, k, d); check(d == 0, "R2 counter", d, 0);
    end
    check(id_fifo_empty && addr_fifo_empty && !id_fifo_full && !addr_fifo_full,
          "R2 flags", {id_fifo_empty, addr_fifo_empty, id_fifo_full, addr_fifo_full}, 4'b1100);
    reg_rd(1, 3, d); check(d == 8'h1f, "R2 head", d, 8'h1f);
    reg_rd(2, 9, d); check(d == 8'h1f, "R2 tail", d, 8'h1f);
    reg_rd(3, 20, d); check(d == 8'h1f, "R2 link", d, 8'h1f);

    // R1 control register
    reg_wr(0, 0, 8'hFE); reg_rd(0, 0, d); check(d == 8'hFE, "R1 store", d, 8'hFE);
    reg_wr(0, 0, 8'h01); reg_rd(0, 0, d); check(d == 8'h00, "R1 reset bit", d, 0);
    reg_wr(0, 0, 8'h5B); reg_rd(0, 0, d); check(d == 8'h00, "R1 reset bit with others", d, 0);
    // R11 counter write ignored
    reg_wr(0, 2, 8'h05); reg_rd(0, 2, d); check(d == 0, "R11 counter write", d, 0);

    // ownership setup through head table (R11)
    for (int c = 0; c < NCONN; c++) reg_wr(1, c, m_own[c] ? 8'h3f : 8'h1f);
    reg_rd(1, 9, d); check(d == 8'h1f, "R11 head own0", d, 8'h1f);
    reg_rd(1, 4, d); check(d == 8'h3f, "R11 head own1", d, 8'h3f);

    // main stream: R4 R5 R6 R7 R8 R9
    reg_wr(0, 0, ACT);
    ide = 0; ade = 0; nga = 0;
    for (int k = 0; k < 40; k++) begin
      int id;
      id = (k * 7 + 3) % 16;
      if (k % 10 == 9) kind = 1;
      else if (k % 13 == 5) kind = 2;
      else if (k % 11 == 4) kind = 3;
      else if (k == 17) kind = 4;
      else if (k == 22) kind = 5;
      else kind = 0;
      case (kind)
        0: begin push(id, nga, 0, 0, 0); model_enq(id, nga); nga++; end
        1: push(id, 3, 1, 1, 1);
        2: begin push(id, 7, 0, 1, 0); ide++; end
        3: begin push(id, 8, 0, 0, 1); ade++; end
        4: begin push(id, 9, 0, 1, 1); ide++; ade++; end
        default: push(id, int'(NP), 0, 0, 0);
      endcase
    end
    repeat (4) @(negedge clk);
    check(id_fifo_empty && addr_fifo_empty, "R1 drained while active",
          {id_fifo_empty, addr_fifo_empty}, 2'b11);

    // R12: register access holds the queue
    set_pair(5, nga, 0, 0, 0);
    reg_en = 1; reg_we = 0; reg_space = 0; reg_addr = 0;
    @(negedge clk);
    in_valid = 0;
    model_enq(5, nga); nga++;
    @(negedge clk);
    check(!id_fifo_empty, "R12 held", id_fifo_empty, 0);
    @(negedge clk);
    check(!id_fifo_empty, "R12 held", id_fifo_empty, 0);
    reg_en = 0;
    @(negedge clk);
    check(id_fifo_empty, "R12 resumed", id_fifo_empty, 1);
    repeat (2) @(negedge clk);

    // parity counters (R5, R10 read-clear)
    reg_rd(0, 1, d); check(d == (ide > CMAX ? CMAX : ide), "R5 id errors", d, ide);
    reg_rd(0, 2, d); check(d == (ade > CMAX ? CMAX : ade), "R5 addr errors", d, ade);
    reg_rd(0, 1, d); check(d == 0, "R10 read clears", d, 0);

    // full table comparison (R6 R7 R8 R4 R9)
    for (int c = 0; c < NCONN; c++) begin
      reg_rd(1, c, d);
      check(d == {2'b0, m_own[c], m_head[c]}, "R7 head", d, {2'b0, m_own[c], m_head[c]});
      reg_rd(2, c, d);
      check(d == {3'b0, m_tail[c]}, m_own[c] ? "R8 tail" : "R6 tail", d, m_tail[c]);
    end
    for (int b = 0; b < NBUF; b++) begin
      reg_rd(3, b, d);
      check(d == {3'b0, m_link[b]}, "R8 link", d, m_link[b]);
    end

    // R3 overflow and same-cycle read-clear (R10)
    reg_wr(0, 0, 8'h00);
    for (int k = 0; k < FIFO_DEPTH; k++) push(k, k, 0, 0, 0);
    check(id_fifo_full && addr_fifo_full, "R3 full", {id_fifo_full, addr_fifo_full}, 2'b11);
    push(1, 1, 0, 0, 0);
    push(2, 2, 0, 0, 0);
    set_pair(3, 3, 0, 0, 0);
    reg_rd(0, 3, d);
    in_valid = 0;
    check(d == 2, "R10 read with increment", d, 2);
    reg_rd(0, 3, d); check(d == 1, "R10 increment kept", d, 1);
    for (int k = 0; k < 9; k++) push(k, k, 0, 0, 0);
    reg_rd(0, 3, d); check(d == CMAX, "R10 saturation", d, CMAX);
    reg_rd(0, 3, d); check(d == 0, "R3 overflow cleared", d, 0);
    check(id_fifo_full, "R1 idle holds queue", id_fifo_full, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule